// File: doc/BRIEF.md
# Multi-Channel Input Debouncer with Edge Pulses

This block cleans up a parallel group of noisy digital inputs such as push buttons, switches or limit sensors. Each raw input first crosses into the clock domain through a two-flop synchroniser. On every cycle in which the sample-enable tick is high, the block takes one sample of all channels at once. A channel's filtered output moves to a new level only when the three most recent samples agree on that level. Any other mix of samples leaves the output where it was.

Each channel also has a rise pulse and a fall pulse. A pulse goes high for exactly one clock cycle when the filtered output of that channel goes up or goes down. Each filtered bit is updated with plain AND/OR terms over the sample window, so all channels work in parallel and no channel has a counter of its own. The tick comes from outside the block. A typical tick rate is about one per millisecond.

Top module: `debounce_bank`

## Requirements
- R1: While rst_n is low at a clock edge, filt_out is set to all ones and rise_pulse and fall_pulse are set to zero. The stored samples are also set to ones, so the first samples after reset give no edge pulse.
- R2: A raw_in value passes through two clocked stages before it can be sampled. A change applied before clock edge A is first taken by a tick at edge A+2. A tick at edge A+1 still takes the old value.
- R3: On a tick edge, a filtered bit takes level v when the sample taken at that edge and the two samples before it all equal v. The new level is visible on filt_out right after that edge.
- R4: On a tick edge where the three samples of a channel do not agree, that channel's filtered bit keeps its value.
- R5: A clock edge with sample_en low changes neither filt_out nor the stored samples, whatever raw_in does.
- R6: rise_pulse[i] is high for exactly one cycle, in the cycle right after the tick edge at which filt_out[i] went from 0 to 1. At all other times it is low.
- R7: fall_pulse[i] is high for exactly one cycle, in the cycle right after the tick edge at which filt_out[i] went from 1 to 0. At all other times it is low.
- R8: The channels are fully independent. What happens on one bit of raw_in never affects the outputs of another bit.
- R9: Feed one channel, one sample per tick, the input sequence 1 0 0 1 0 1 0 0 0 1 0 1 1 1. After each tick its filtered output reads 1 1 1 1 1 1 1 1 0 0 0 0 0 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_en | input | 1 | Sample tick; one sample is taken on each edge where it is high |
| raw_in | input | CHANNELS | Noisy asynchronous inputs |
| filt_out | output | CHANNELS | Debounced levels |
| rise_pulse | output | CHANNELS | One-cycle pulse when a debounced level rises |
| fall_pulse | output | CHANNELS | One-cycle pulse when a debounced level falls |

## Verification
A raw change reaches the sampling point two edges after it is applied. A filtered level and its edge pulse both appear right after the tick edge that completes a run of three agreeing samples. The pulse falls again one cycle later. The bench applies inputs shortly after each falling clock edge and samples outputs at the next falling edge, so each result is read half a cycle after the rising edge that produced it. The behavioural reference model steps on the same rising edges, modelling the two-stage delay and a per-channel run count. The directed checks count the edges between each stimulus and its tick, to pin down the exact sampling edge, the edge on which a level changes and the one-cycle pulse length.

// File: rtl/dbn_pkg.sv
// Shared constants for the debouncer bank.
// Assumes: filter window of at least two samples, synchroniser of at least two stages.
package dbn_pkg;
    localparam int unsigned DBN_WINDOW      = 3;    // samples that must agree
    localparam int unsigned DBN_SYNC_STAGES = 2;    // clock-crossing flops
    localparam logic        DBN_IDLE_LEVEL  = 1'b1; // reset level of every channel
endpackage

// File: rtl/dbn_sync.sv
// Multi-stage synchroniser for a bus of asynchronous inputs.
// Assumes: each bit is independent; no bus coherency is needed.
module dbn_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2,
    parameter logic        INIT   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [0:STAGES-1];

    // Shift the inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= {WIDTH{INIT}};
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/dbn_window_filter.sv
// Sample history and unanimity filter. On every tick the newest sample and the
// stored ones form a window; a bit becomes 1 if all agree on 1, becomes 0 if
// all agree on 0, and holds otherwise.
// Assumes: WINDOW >= 2; samp_in is already synchronous.
module dbn_window_filter #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned WINDOW = 3,
    parameter logic        INIT   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic [WIDTH-1:0] samp_in,
    output logic [WIDTH-1:0] filt_q,
    output logic [WIDTH-1:0] filt_next
);
    localparam int unsigned HIST_REGS = WINDOW - 1;

    logic [WIDTH-1:0] hist_q [0:HIST_REGS-1];
    logic [WIDTH-1:0] all_one;
    logic [WIDTH-1:0] any_one;

    // Reduce the window bitwise into "all ones" and "any one" terms.
    always_comb begin
        all_one = samp_in;
        any_one = samp_in;
        for (int k = 0; k < HIST_REGS; k++) begin
            all_one = all_one & hist_q[k];
            any_one = any_one | hist_q[k];
        end
        filt_next = (filt_q & any_one) | all_one;
    end

    // Advance history and filtered level on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < HIST_REGS; k++) hist_q[k] <= {WIDTH{INIT}};
            filt_q <= {WIDTH{INIT}};
        end else if (sample_en) begin
            hist_q[0] <= samp_in;
            for (int k = 1; k < HIST_REGS; k++) hist_q[k] <= hist_q[k-1];
            filt_q <= filt_next;
        end
    end

    // A changed bit must have moved toward the sample taken at that edge.
    AST_CHANGE_TOWARD_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((filt_q ^ $past(filt_q)) & (filt_q ^ $past(samp_in))) == '0); // R3

    // A changed bit must have seen the newest two samples agree.
    AST_CHANGE_NEEDS_AGREEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((filt_q ^ $past(filt_q)) & ($past(hist_q[0]) ^ $past(samp_in))) == '0); // R4
endmodule

// File: rtl/dbn_edge_pulse.sv
// Registered rise and fall pulses of the filtered levels. A pulse is set at
// the tick edge that changes the level and clears on the next edge.
// Assumes: filt_next is the value filt_q takes at a tick edge.
module dbn_edge_pulse #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic [WIDTH-1:0] filt_q,
    input  logic [WIDTH-1:0] filt_next,
    output logic [WIDTH-1:0] rise_q,
    output logic [WIDTH-1:0] fall_q
);
    // Capture level changes made at a tick; clear the pulses otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
        end else if (sample_en) begin
            rise_q <= filt_next & ~filt_q;
            fall_q <= ~filt_next & filt_q;
        end else begin
            rise_q <= '0;
            fall_q <= '0;
        end
    end

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_q & fall_q) == '0); // R6

    AST_PULSE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_q | fall_q) & $past(rise_q | fall_q)) == '0); // R7
endmodule

// File: rtl/debounce_bank.sv
// Top of the debouncer bank: synchroniser, window filter and edge pulses.
// Assumes: sample_en is a one-cycle tick from an external timebase.
module debounce_bank
    import dbn_pkg::*;
#(
    parameter int unsigned CHANNELS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_en,
    input  logic [CHANNELS-1:0] raw_in,
    output logic [CHANNELS-1:0] filt_out,
    output logic [CHANNELS-1:0] rise_pulse,
    output logic [CHANNELS-1:0] fall_pulse
);
    logic [CHANNELS-1:0] sync_w;
    logic [CHANNELS-1:0] filt_w;
    logic [CHANNELS-1:0] next_w;

    dbn_sync #(.WIDTH(CHANNELS), .STAGES(DBN_SYNC_STAGES), .INIT(DBN_IDLE_LEVEL)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(raw_in), .sync_out(sync_w)
    );

    dbn_window_filter #(.WIDTH(CHANNELS), .WINDOW(DBN_WINDOW), .INIT(DBN_IDLE_LEVEL)) filt_i (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .samp_in(sync_w),
        .filt_q(filt_w), .filt_next(next_w)
    );

    dbn_edge_pulse #(.WIDTH(CHANNELS)) edge_i (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .filt_q(filt_w),
        .filt_next(next_w), .rise_q(rise_pulse), .fall_q(fall_pulse)
    );

    assign filt_out = filt_w;

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sample_en) |-> $stable(filt_out)); // R5

    AST_RISE_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_pulse & ~(filt_out & ~$past(filt_out))) == '0); // R6

    AST_FALL_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_pulse & ~(~filt_out & $past(filt_out))) == '0); // R7
endmodule

// File: tb/debounce_bank_tb_top.sv
module debounce_bank_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sample_en = 1'b0;
    logic [W-1:0] raw_in = '1;
    logic [W-1:0] filt_out, rise_pulse, fall_pulse;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;
    string filt_tag = "R3/R4";

    always #4 clk = ~clk;

    debounce_bank #(.CHANNELS(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .raw_in(raw_in),
        .filt_out(filt_out), .rise_pulse(rise_pulse), .fall_pulse(fall_pulse)
    );

    // Behavioural reference: two-edge delay, then per-channel run length.
    logic [W-1:0] d1, d2, m_filt, m_rise, m_fall;
    logic [W-1:0] last_v;
    int           run_len [W];

    always @(posedge clk) begin
        logic [W-1:0] samp;
        if (!rst_n) begin
            d1 = '1; d2 = '1; m_filt = '1; m_rise = '0; m_fall = '0; last_v = '1;
            for (int i = 0; i < W; i++) run_len[i] = 2;
            model_on = 1'b1;
        end else begin
            samp = d2; d2 = d1; d1 = raw_in;
            m_rise = '0; m_fall = '0;
            if (sample_en) begin
                for (int i = 0; i < W; i++) begin
                    if (samp[i] == last_v[i]) run_len[i]++;
                    else begin run_len[i] = 1; last_v[i] = samp[i]; end
                    if (run_len[i] >= 3 && m_filt[i] != last_v[i]) begin
                        if (last_v[i]) m_rise[i] = 1'b1; else m_fall[i] = 1'b1;
                        m_filt[i] = last_v[i];
                    end
                end
            end
        end
    end

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (model_on && !done) begin
            check(filt_tag, filt_out, m_filt);
            check("R6", rise_pulse, m_rise);
            check("R7", fall_pulse, m_fall);
        end
    end

    // One sample: value present two edges before its tick; returns filt after the tick.
    task automatic apply_sample(input logic [W-1:0] v, output logic [W-1:0] got);
        @(negedge clk); #1 raw_in = v;
        @(negedge clk);
        @(negedge clk); #1 sample_en = 1'b1;
        @(negedge clk); got = filt_out; #1 sample_en = 1'b0;
    endtask

    // Change all raw bits, tick continuously, check exact change edge and pulse.
    task automatic step_all(input logic v);
        @(negedge clk); #1 raw_in = {W{v}};                          // before edge A
        @(negedge clk); #1 sample_en = 1'b1;                         // before A+1
        @(negedge clk);                                              // after A+1
        @(negedge clk);                                              // after A+2
        @(negedge clk); check("R2", filt_out, {W{~v}});              // after A+3
        @(negedge clk); check("R3", filt_out, {W{v}});               // after A+4
        if (v) check("R6", rise_pulse, '1); else check("R7", fall_pulse, '1);
        #1 sample_en = 1'b0;
        @(negedge clk);
        if (v) check("R6", rise_pulse, '0); else check("R7", fall_pulse, '0);
    endtask

    initial begin
        automatic logic [13:0] seq_in  = 14'b1_0_0_1_0_1_0_0_0_1_0_1_1_1;
        automatic logic [13:0] seq_out = 14'b1_1_1_1_1_1_1_1_0_0_0_0_0_1;
        automatic logic [15:0] lfsr = 16'hACE1;
        logic [W-1:0] got, held;

        repeat (5) @(negedge clk);
        check("R1", filt_out, '1);
        check("R1", rise_pulse | fall_pulse, '0);
        #1 rst_n = 1'b1;
        // R1: first ticks with ones give no pulse (model compare)
        apply_sample('1, got); check("R1", got, '1);

        step_all(1'b0);
        step_all(1'b1);

        // R9 reference sequence on channel 0; upper channels held at 1010101.
        for (int k = 13; k >= 0; k--) begin
            apply_sample({7'b1010101, seq_in[k]}, got);
            checks++;
            if (got[0] !== seq_out[k]) begin
                errors++;
                $display("FAIL R9/R4: step %0d got %b expected %b", 13 - k, got[0], seq_out[k]);
            end
        end
        check("R8", {1'b0, filt_out[W-1:1]}, {1'b0, 7'b1010101});

        // R5: raw activity without ticks leaves outputs and history alone.
        filt_tag = "R5";
        held = filt_out;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk); #1 raw_in = ~raw_in;
        end
        @(negedge clk); check("R5", filt_out, held);
        apply_sample(~held, got); check("R5", got, held);
        filt_tag = "R3/R4";

        // Mixed random stimulus compared each clock against the model.
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'd0) raw_in = raw_in ^ lfsr[15:8];
            sample_en = (lfsr[6:4] == 3'd0);
        end
        @(negedge clk); #1 sample_en = 1'b0;
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule